// File: doc/BRIEF.md
# Four-Channel PWM Timer with Armed Shadow Reload

This block is a 16-bit up-counting timer that drives three pulse-width-modulated outputs. Compare slot 0 sets the period and slots 1 to 3 set the duty of the three outputs. The comparators never look at the writable compare registers directly. They use a shadow copy of each one. This lets software rewrite several settings while the timer is running without ever producing a period built from mixed old and new values.

While the timer runs, the shadows change only when software has armed a reload and the counter then wraps. Software arms a reload by writing compare slot 1, even when it writes the same value. The usual update order is to write slots 0, 2 and 3 first and slot 1 last, so that every change commits at one wrap. While the timer is stopped, writes pass straight into the shadows, so the initial setup is live on the first count. A 3-bit divider select picks the count rate, from every system clock down to every 128th clock. The divider select can be written in the same control write that starts the timer.

Top module: `pwm_reload_timer`

## Requirements
- R1: While running, the counter steps 0, 1, ..., S0 on count ticks and returns to 0 on the tick after it equals shadow 0 (S0). One period is (S0+1) ticks, and `period_pulse` is high for exactly one clock per period, in the last clock of the period.
- R2: Writing address 4 sets the control register: bit 0 is the run enable and bits 3:1 are the divider code n. Count ticks occur every 2^n clocks, for n = 0..7. Both fields may be set in one write.
- R3: Output k (k = 1..3, on `pwm_out[k-1]`) is high while the counter is below shadow k and low otherwise. A shadow of 0 keeps it low for the whole period. A shadow above S0 keeps it high for the whole period.
- R4: While stopped, writes to addresses 0..3 update both the register and its shadow, the outputs and `period_pulse` are low, the counter is held at 0, and `reload_pending` stays 0.
- R5: While running, writes to addresses 0, 2 and 3 with no later write to address 1 leave the period and the duties unchanged.
- R6: While running, a write to address 1 sets `reload_pending`. At the next counter wrap, all four shadows take their register values and `reload_pending` returns to 0.
- R7: A write to address 1 in the same clock as a wrap does not commit at that wrap. The wrap uses the shadows already held, and the new arming commits at the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 3 | Write address: 0..3 compare slots, 4 control |
| wr_data | input | 16 | Write data |
| pwm_out | output | 3 | Duty outputs of channels 1..3 |
| period_pulse | output | 1 | High in the clock of the tick on which the counter wraps |
| reload_pending | output | 1 | An armed reload is waiting for the next wrap |

## Verification
A write that arms a reload and the counter wrap that applies reloads can land in the same clock. This is the case where an arming could be lost or could commit values that are half old and half new. The bench waits until it sees `period_pulse`, then issues the slot-1 write in that same clock. It checks three things: `reload_pending` is still set afterwards, the period that follows keeps the old length, and the period after that has the new length and duties. The other checks are sweeps over every divider code and several periods. These measure period length, pulse count and high time per output, and compare them against products of the divider and the programmed values.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  // Address of the control register on the write port
  localparam int unsigned CTRL_ADDR    = 4;
  // Control register field positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SEL_LSB = 1;
  // Compare slot that sets the period
  localparam int unsigned PERIOD_SLOT  = 0;
  // Compare slot whose write arms the shadow reload
  localparam int unsigned ARM_SLOT     = 1;
endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  // divide by 2^sel: tick when the low sel bits are all ones
  always_comb begin
    mask  = (PRE_W'(1) << div_sel) - PRE_W'(1);
    tick  = run_en && ((pre_q & mask) == mask);
    pre_d = run_en ? pre_q + PRE_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: no ticks while stopped
  assert_tick_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick);

  // R2: with a divider above 1, two ticks never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && div_sel != '0 && tick) |=> (div_sel == '0 || !tick));
endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          wrap,
  output logic                          run_en,
  output logic [SEL_W-1:0]              div_sel,
  output logic [NUM_CH-1:0][CNT_W-1:0]  shadow,
  output logic                          pending
);
  localparam int unsigned SEL_MSB = CTRL_SEL_LSB + SEL_W - 1;

  logic [NUM_CH-1:0][CNT_W-1:0] reg_q, reg_d, shd_q, shd_d;
  logic                         en_q, en_d;
  logic [SEL_W-1:0]             sel_q, sel_d;
  logic                         pend_q, pend_d;
  logic                         wr_ctl, wr_arm, commit;

  always_comb begin
    wr_ctl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    wr_arm = wr_en && (wr_addr == ADDR_W'(ARM_SLOT));
    commit = en_q && wrap && pend_q;

    for (int i = 0; i < NUM_CH; i++) begin
      reg_d[i] = (wr_en && wr_addr == ADDR_W'(i)) ? wr_data : reg_q[i];
      if (!en_q)       shd_d[i] = reg_d[i];   // stopped: pass-through
      else if (commit) shd_d[i] = reg_q[i];   // armed wrap: bulk copy
      else             shd_d[i] = shd_q[i];
    end

    en_d  = wr_ctl ? wr_data[CTRL_EN_BIT]      : en_q;
    sel_d = wr_ctl ? wr_data[SEL_MSB:CTRL_SEL_LSB] : sel_q;

    if (!en_q)       pend_d = 1'b0;
    else if (wr_arm) pend_d = 1'b1;
    else if (commit) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      shd_q  <= '0;
      en_q   <= 1'b0;
      sel_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      reg_q  <= reg_d;
      shd_q  <= shd_d;
      en_q   <= en_d;
      sel_q  <= sel_d;
      pend_q <= pend_d;
    end
  end

  assign run_en  = en_q;
  assign div_sel = sel_q;
  assign shadow  = shd_q;
  assign pending = pend_q;

  // R5: while running, shadows move only on an armed wrap
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(wrap && pend_q)) |=> $stable(shd_q));

  // R6: an armed wrap copies every register into its shadow
  assert_bulk_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wrap && pend_q) |=> (shd_q == $past(reg_q)));

  // R6: the pending flag drops after the copy when nothing re-arms it
  assert_pending_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wrap && pend_q && !wr_arm) |=> !pend_q);

  // R7: arming in a wrap clock survives that wrap
  assert_arm_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wrap && wr_arm) |=> pend_q);

  // R4: stopped timer never reports a pending reload
  assert_no_pend_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !pend_q);
endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == top_val);
    wrap   = tick && at_top;
    if (!run_en)     cnt_d = '0;
    else if (wrap)   cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R1: a tick at the top value returns the counter to zero
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && cnt_q == top_val) |=> (cnt_q == '0));

  // R1: the counter never passes the period value
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (cnt_q <= top_val));

  // R4: counter held at zero while stopped
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_tmr_outs.sv
module pwm_tmr_outs #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_en,
  input  logic [CNT_W-1:0]              count,
  input  logic [NUM_CH-2:0][CNT_W-1:0]  duty,
  output logic [NUM_CH-2:0]             pwm
);
  for (genvar k = 0; k < NUM_CH - 1; k++) begin : g_ch
    // high from the wrap until the count reaches the duty value
    assign pwm[k] = run_en && (count < duty[k]);

    // R3: a zero duty keeps the channel low
    assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (duty[k] == '0) |-> !pwm[k]);
  end

  // R4: all outputs low while stopped
  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (pwm == '0));
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-2:0] pwm_out,
  output logic              period_pulse,
  output logic              reload_pending
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_core_n;
  logic                         run_en, tick, wrap;
  logic [SEL_W-1:0]             div_sel;
  logic [NUM_CH-1:0][CNT_W-1:0] shadow;
  logic [NUM_CH-2:0][CNT_W-1:0] duty;
  logic [CNT_W-1:0]             count;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pwm_tmr_regs #(
    .CNT_W (CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wrap   (wrap),
    .run_en (run_en),
    .div_sel(div_sel),
    .shadow (shadow),
    .pending(reload_pending)
  );

  pwm_tmr_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_en (run_en),
    .div_sel(div_sel),
    .tick   (tick)
  );

  pwm_tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_en (run_en),
    .tick   (tick),
    .top_val(shadow[PERIOD_SLOT]),
    .count  (count),
    .wrap   (wrap)
  );

  assign duty = shadow[NUM_CH-1:1];

  pwm_tmr_outs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_outs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run_en(run_en),
    .count (count),
    .duty  (duty),
    .pwm   (pwm_out)
  );

  assign period_pulse = wrap;
endmodule

// File: tb/pwm_reload_timer_bench.sv
module pwm_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  pwm_out;
  logic        period_pulse;
  logic        reload_pending;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  pwm_reload_timer u_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .period_pulse(period_pulse),
    .reload_pending(reload_pending)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; write captured at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    while (period_pulse !== 1'b1) @(negedge clk);
  endtask

  // one full period between two wraps: length, high times, pulse count
  task automatic measure(output int len, output int h1, output int h2, output int h3,
                         output int pulses);
    len = 0; h1 = 0; h2 = 0; h3 = 0; pulses = 0;
    @(negedge clk);
    wait_pulse();
    do begin
      @(negedge clk);
      len++;
      h1 += int'(pwm_out[0]);
      h2 += int'(pwm_out[1]);
      h3 += int'(pwm_out[2]);
      pulses += int'(period_pulse);
    end while (period_pulse !== 1'b1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-reqs: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int len, h1, h2, h3, pl;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R4)
    check("R4", "reset pwm", int'(pwm_out), 0);
    check("R4", "reset pulse", int'(period_pulse), 0);
    check("R4", "reset pending", int'(reload_pending), 0);

    // sweep every divider code and several periods (R1 R2 R3 R4)
    for (int sel = 0; sel < 8; sel++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int p, dv;
        p  = (pi == 0) ? 0 : (pi == 1) ? 2 : 5;
        dv = 1 << sel;
        wr(3'd4, 16'd0);
        wr(3'd0, 16'(p));
        wr(3'd1, 16'd0);
        wr(3'd2, 16'(p));
        wr(3'd3, 16'(p + 1));
        wr(3'd4, 16'((sel << 1) | 1));   // divider and enable in one write
        measure(len, h1, h2, h3, pl);
        check("R1_R2", $sformatf("period sel%0d top%0d", sel, p), len, (p + 1) * dv);
        check("R1", $sformatf("pulses sel%0d top%0d", sel, p), pl, 1);
        check("R3", $sformatf("zero duty sel%0d top%0d", sel, p), h1, 0);
        check("R3", $sformatf("mid duty sel%0d top%0d", sel, p), h2, p * dv);
        check("R3", $sformatf("over duty sel%0d top%0d", sel, p), h3, (p + 1) * dv);
      end
    end

    // reload arming at divider 1
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd1);
    measure(len, h1, h2, h3, pl);
    check("R1", "base period", len, 4);
    check("R3", "base duty1", h1, 2);

    // R5: writes to 0, 2, 3 alone change nothing
    @(negedge clk);
    wr(3'd0, 16'd5);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd3);
    for (int r = 0; r < 2; r++) begin
      measure(len, h1, h2, h3, pl);
      check("R5", "period kept", len, 4);
      check("R5", "duty1 kept", h1, 2);
      check("R5", "duty2 kept", h2, 1);
      check("R5", "duty3 kept", h3, 4);
    end
    check("R5", "no pending", int'(reload_pending), 0);

    // R6: slot-1 write with unchanged value commits everything
    @(negedge clk);
    wr(3'd1, 16'd2);
    check("R6", "pending set", int'(reload_pending), 1);
    measure(len, h1, h2, h3, pl);
    check("R6", "new period", len, 6);
    check("R6", "new duty1", h1, 2);
    check("R6", "new duty2", h2, 0);
    check("R6", "new duty3", h3, 3);
    check("R6", "pending cleared", int'(reload_pending), 0);

    // R7: arming in the wrap clock commits one wrap later
    @(negedge clk);
    wr(3'd0, 16'd2);
    wait_pulse();
    wr(3'd1, 16'd1);
    check("R7", "pending after wrap-clock arm", int'(reload_pending), 1);
    len = 1;
    while (period_pulse !== 1'b1) begin
      @(negedge clk);
      len++;
    end
    check("R7", "old period kept", len, 6);
    check("R7", "pending held", int'(reload_pending), 1);
    measure(len, h1, h2, h3, pl);
    check("R7", "period after commit", len, 3);
    check("R7", "duty1 after commit", h1, 1);
    check("R7", "duty3 after commit", h3, 3);
    check("R7", "pending dropped", int'(reload_pending), 0);

    // R4: stopping clears outputs; slot-1 write arms nothing
    @(negedge clk);
    wr(3'd4, 16'd0);
    for (int c = 0; c < 6; c++) begin
      check("R4", "stopped pwm", int'(pwm_out), 0);
      check("R4", "stopped pulse", int'(period_pulse), 0);
      @(negedge clk);
    end
    wr(3'd1, 16'd9);
    check("R4", "stopped pending", int'(reload_pending), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule